// File: doc/BRIEF.md
# Multi-Format RGB Pixel Unpacker

This block takes a stream of 16-bit host words and turns it into 32-bit RGB pixels. The pixels are 8 bits per channel, with the top byte always zero. A 4-bit format code picks how the host packed its pixels. The choices are 16-bit 5:6:5, a 3-byte packing that yields two pixels from every three words, and a 4-byte packing that yields one pixel from every two words. For each packing, the 6:6:6 and 8:8:8 variants are decoded by the same path.

The block also reports the number of bytes each pixel occupies in the selected format. Upstream logic uses that value to size a transfer before it starts sending words. A format the block cannot decode reports zero bytes and raises an unsupported flag. Words sent in such a format are taken and discarded.

Both sides use valid/ready handshakes. A single output register holds the current pixel. The input stalls while that register holds a pixel that downstream has not yet taken. A partly assembled pixel is kept across any number of idle or stalled cycles.

Top module: `rgb_unpacker`

## Requirements
- R1: `bpp` reports the bytes per pixel for the current `fmt`: 2 for code 1, 3 for codes 2 and 3, 4 for codes 5 and 6, and 0 for every other code.
- R2: `fmt_bad` is 1 exactly when `bpp` is 0.
- R3: In format 1, each accepted word `d` produces one pixel with layout {8'h00, R, G, B} on `px_data[31:0]`. R is d[15:11] followed by three zero bits. G is d[10:5] followed by two zero bits. B is d[4:0] followed by three zero bits. No low bits are replicated.
- R4: In formats 2 and 3, three words w0, w1, w2 produce two pixels. The first pixel appears after w1 and is R=w0[7:0], G=w0[15:8], B=w1[7:0]. The second appears after w2 and is R=w1[15:8], G=w2[7:0], B=w2[15:8]. Codes 2 and 3 behave identically.
- R5: In formats 5 and 6, two words w0, w1 produce one pixel after w1: R=w0[7:0], G=w0[15:8], B=w1[7:0]. w1[15:8] is ignored.
- R6: When `fmt_bad` is 1, offered words are accepted and produce no pixel.
- R7: While `px_valid` is 1 and `px_ready` is 0, `in_ready` is 0 and `px_data` holds its value.
- R8: If `fmt` differs from its value on the previous clock, any partly assembled pixel is dropped. The next accepted word is then treated as the first word of a pixel.
- R9: After reset, `px_valid` is 0, `in_ready` is 1 and assembly starts at the first word of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 4 | Input packing code |
| in_valid | input | 1 | Host word valid |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | Block can take a word this cycle |
| px_valid | output | 1 | Pixel valid |
| px_data | output | 32 | Pixel {8'h00, R, G, B} |
| px_ready | input | 1 | Downstream takes the pixel |
| bpp | output | 3 | Bytes per pixel for `fmt` |
| fmt_bad | output | 1 | Current format is unsupported |

## Verification
The assertions check on every cycle the properties that do not depend on pixel content:
- the bytes-per-pixel code stays legal and agrees with the unsupported flag;
- a stalled pixel stays frozen while input is refused;
- an unsupported word never yields a pixel;
- a 5:6:5 word always yields a pixel with zero low bits;
- the first word after a format change never completes a 3-byte pixel.

The exact byte placement across word boundaries in the 3-byte and 4-byte packings can only be shown by the bench scenarios. So can the dropping of a half-built pixel on a format change and the ordering of pixels under random backpressure. The bench compares each of these against a model of its own.

// File: rtl/rgb_unpacker.sv
module rgb_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fmt,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  output logic        px_valid,
  output logic [31:0] px_data,
  input  logic        px_ready,
  output logic [2:0]  bpp,
  output logic        fmt_bad
);

  typedef enum logic [1:0] {K_NONE, K_565, K_TRI, K_QUAD} kind_t;

  kind_t       kind;
  logic [1:0]  phase, eff_ph, nxt_ph;
  logic [15:0] hold;
  logic [3:0]  fmt_q;
  logic        fire, load, store;
  logic [31:0] pix;

  always_comb begin
    case (fmt)
      4'd1:       begin kind = K_565;  bpp = 3'd2; end
      4'd2, 4'd3: begin kind = K_TRI;  bpp = 3'd3; end
      4'd5, 4'd6: begin kind = K_QUAD; bpp = 3'd4; end
      default:    begin kind = K_NONE; bpp = 3'd0; end
    endcase
  end

  assign fmt_bad  = (kind == K_NONE);
  assign in_ready = !px_valid || px_ready;
  assign fire     = in_valid && in_ready;
  assign eff_ph   = (fmt != fmt_q) ? 2'd0 : phase;

  always_comb begin
    nxt_ph = 2'd0;
    load   = 1'b0;
    store  = 1'b0;
    pix    = 32'd0;
    case (kind)
      K_565: begin
        load = 1'b1;
        pix  = {8'h00, in_data[15:11], 3'b000, in_data[10:5], 2'b00, in_data[4:0], 3'b000};
      end
      K_TRI: begin
        case (eff_ph)
          2'd0: begin nxt_ph = 2'd1; store = 1'b1; end
          2'd1: begin
            nxt_ph = 2'd2; store = 1'b1; load = 1'b1;
            pix = {8'h00, hold[7:0], hold[15:8], in_data[7:0]};
          end
          default: begin
            load = 1'b1;
            pix = {8'h00, hold[15:8], in_data[7:0], in_data[15:8]};
          end
        endcase
      end
      K_QUAD: begin
        if (eff_ph == 2'd0) begin
          nxt_ph = 2'd1; store = 1'b1;
        end else begin
          load = 1'b1;
          pix = {8'h00, hold[7:0], hold[15:8], in_data[7:0]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 2'd0;
      hold     <= 16'd0;
      fmt_q    <= 4'd0;
      px_valid <= 1'b0;
      px_data  <= 32'd0;
    end else begin
      fmt_q <= fmt;
      if (fire) begin
        phase <= nxt_ph;
        if (store) hold <= in_data;
      end else begin
        phase <= eff_ph;
      end
      if (fire && load) begin
        px_valid <= 1'b1;
        px_data  <= pix;
      end else if (px_ready) begin
        px_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rst_n) begin
      p_bpp_legal_r1: assert (bpp != 3'd1 && bpp <= 3'd4);
    end
  end

  p_flag_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_bad |-> (bpp == 3'd0));

  p_565_lsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fmt == 4'd1) |=> (px_valid && px_data[31:24] == 8'h00 &&
      px_data[18:16] == 3'b000 && px_data[9:8] == 2'b00 && px_data[2:0] == 3'b000));

  p_bad_no_pixel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fmt_bad) |=> !px_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data)));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |-> !in_ready);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fmt != fmt_q && (fmt == 4'd2 || fmt == 4'd3)) |=> !px_valid);

endmodule

// File: tb/rgb_unpacker_test.sv
module rgb_unpacker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fmt;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic        px_valid;
  logic [31:0] px_data;
  logic        px_ready;
  logic [2:0]  bpp;
  logic        fmt_bad;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  m_prev;
  int          m_ph;
  logic [15:0] m_hold;
  bit          accepted;
  bit          stall_chk;
  logic [31:0] stall_val;

  rgb_unpacker uut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
    .bpp(bpp), .fmt_bad(fmt_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_bpp(logic [3:0] f);
    case (f)
      4'd1: return 3'd2;
      4'd2, 4'd3: return 3'd3;
      4'd5, 4'd6: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] px565(logic [15:0] d);
    return {8'h00, d[15:11], 3'b000, d[10:5], 2'b00, d[4:0], 3'b000};
  endfunction

  task automatic model(logic [15:0] d);
    int ph;
    ph = (fmt != m_prev) ? 0 : m_ph;
    m_ph = 0;
    case (fmt)
      4'd1: begin exp_q.push_back(px565(d)); tag_q.push_back("R3"); end
      4'd2, 4'd3: begin
        if (ph == 0) begin m_hold = d; m_ph = 1; end
        else if (ph == 1) begin
          exp_q.push_back({8'h00, m_hold[7:0], m_hold[15:8], d[7:0]});
          tag_q.push_back("R4");
          m_hold = d; m_ph = 2;
        end else begin
          exp_q.push_back({8'h00, m_hold[15:8], d[7:0], d[15:8]});
          tag_q.push_back("R4");
        end
      end
      4'd5, 4'd6: begin
        if (ph == 0) begin m_hold = d; m_ph = 1; end
        else begin
          exp_q.push_back({8'h00, m_hold[7:0], m_hold[15:8], d[7:0]});
          tag_q.push_back("R5");
        end
      end
      default: ;
    endcase
  endtask

  task automatic cycle(bit v, logic [15:0] d, bit rdy);
    string t;
    logic [31:0] e;
    in_valid = v; in_data = d; px_ready = rdy;
    #1;
    accepted = v && in_ready;
    if (px_valid && px_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected pixel", px_data, 32'hx);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(px_data === e, t, px_data, e);
      end
    end
    stall_chk = px_valid && !px_ready;
    if (stall_chk) begin
      stall_val = px_data;
      chk(in_ready == 1'b0, "R7 in_ready", {31'd0, in_ready}, 32'd0);
    end
    if (accepted) model(d);
    else if (fmt != m_prev) m_ph = 0;
    m_prev = fmt;
    @(posedge clk); @(negedge clk);
    if (stall_chk)
      chk(px_valid && px_data === stall_val, "R7 hold", px_data, stall_val);
  endtask

  task automatic send(logic [15:0] d, bit rnd_ready);
    do cycle(1'b1, d, rnd_ready ? 1'($urandom_range(0, 3) != 0) : 1'b1);
    while (!accepted);
  endtask

  task automatic drain();
    repeat (4) cycle(1'b0, 16'h0, 1'b1);
    chk(exp_q.size() == 0, "R4/R5 all pixels delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; fmt = 4'd1; in_valid = 0; in_data = 0; px_ready = 1;
    m_prev = 4'd0; m_ph = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(px_valid == 1'b0, "R9 px_valid", {31'd0, px_valid}, 0);
    chk(in_ready == 1'b1, "R9 in_ready", {31'd0, in_ready}, 1);
    @(negedge clk);

    for (int f = 0; f < 16; f++) begin
      fmt = 4'(f); #1;
      chk(bpp == exp_bpp(4'(f)), "R1 bpp", {29'd0, bpp}, {29'd0, exp_bpp(4'(f))});
      chk(fmt_bad == (exp_bpp(4'(f)) == 0), "R2 fmt_bad", {31'd0, fmt_bad},
          {31'd0, exp_bpp(4'(f)) == 3'd0});
    end

    // R3 directed corners
    fmt = 4'd1; cycle(1'b0, 16'h0, 1'b1);
    send(16'hFFFF, 0); send(16'h0000, 0); send(16'h8410, 0); send(16'h07E0, 0);
    drain();

    // R4 directed: 3-byte packing, then R9 start after reset behaviour checked by phase 0
    fmt = 4'd2; cycle(1'b0, 16'h0, 1'b1);
    send(16'h2211, 0); send(16'h4433, 0); send(16'h6655, 0);
    drain();
    fmt = 4'd3; cycle(1'b0, 16'h0, 1'b1);
    send(16'hBBAA, 0); send(16'hDDCC, 0); send(16'hFFEE, 0);
    drain();

    // R5 directed: high byte of second word ignored
    fmt = 4'd5; cycle(1'b0, 16'h0, 1'b1);
    send(16'h3412, 0); send(16'hFF56, 0);
    fmt = 4'd6; cycle(1'b0, 16'h0, 1'b1);
    send(16'h0102, 0); send(16'h0003, 0);
    drain();

    // R6: unsupported formats swallow words
    fmt = 4'd4; cycle(1'b0, 16'h0, 1'b1);
    for (int i = 0; i < 5; i++) send(16'($urandom), 0);
    fmt = 4'd15; cycle(1'b0, 16'h0, 1'b1);
    for (int i = 0; i < 5; i++) send(16'($urandom), 0);
    cycle(1'b0, 16'h0, 1'b1);
    chk(px_valid == 1'b0, "R6 no pixel", {31'd0, px_valid}, 0);
    drain();

    // R8: format change drops a partial pixel
    fmt = 4'd2; cycle(1'b0, 16'h0, 1'b1);
    send(16'h1111, 0); send(16'h2222, 0);
    fmt = 4'd1; send(16'hF800, 0);
    fmt = 4'd5; send(16'hABCD, 0);
    fmt = 4'd6; send(16'h1234, 0); send(16'h0056, 0);
    drain();

    // R7 directed stall
    fmt = 4'd1; cycle(1'b0, 16'h0, 1'b1);
    send(16'h1234, 0);
    repeat (3) cycle(1'b1, 16'h5678, 1'b0);
    drain();

    // random mix
    for (int blk = 0; blk < 200; blk++) begin
      case ($urandom_range(0, 6))
        0: fmt = 4'd1;
        1: fmt = 4'd2;
        2: fmt = 4'd3;
        3: fmt = 4'd5;
        4: fmt = 4'd6;
        default: fmt = 4'($urandom);
      endcase
      for (int i = 0; i < int'($urandom_range(1, 12)); i++) begin
        if ($urandom_range(0, 3) == 0) cycle(1'b0, 16'h0, 1'($urandom_range(0, 1)));
        send(16'($urandom), 1);
      end
    end
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule